// File: doc/BRIEF.md
# Sampling ADC conversion sequencer

This block runs an external edge-triggered 12-bit sampling converter from the logic side of the board. A conversion starts on a single request pulse, or on a period tick when free-running mode is on. The block drives the converter's start line high for a programmed number of cycles. It then follows the converter's end-of-conversion line through a two-flop synchronizer: first the rise, then the fall. After the fall it waits a programmed settle count, captures the parallel word and offers it on a valid/ready output together with a wrapping sample number.

The converter has no pipeline, so the captured word always belongs to the start that was issued last. A second start while a conversion is still running would spoil two results. The sequencer therefore refuses any request while a sequence is in progress or while the synchronized end-of-conversion line is high. In strict mode it records such a request in a sticky flag. It also records a converter that never answers, or never finishes, in a sticky timeout flag, and then goes back to idle without emitting data.

In free-running mode a new start waits until the previous word has been taken. With the drop-oldest option set, the new word replaces the one that was not taken, and an overrun counter counts each replacement. Start width, settle delay, sample period and both timeout limits are cycle counts held on configuration inputs.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, adc_start, out_valid and busy are 0, out_count and overrun_count are 0, and err_proto and err_timeout are 0.
- R2: A request accepted while idle drives adc_start high for exactly cfg_start_width cycles; a width of 0 behaves as 1.
- R3: adc_start never rises while a sequence is in progress or while the synchronized end-of-conversion level is high, and busy is 1 whenever adc_start is 1.
- R4: out_valid rises exactly cfg_settle+4 clock cycles after adc_eoc falls: 2 cycles in the synchronizer, 1 to detect the fall, then cfg_settle+1 in the settle state. The word on out_data is adc_data as sampled at that capture, which is the result of the most recent start.
- R5: While out_valid is 1 and out_ready is 0, out_valid and out_data stay unchanged. In the cycle after out_ready is seen with out_valid, out_valid is 0, unless a new word is captured in that same cycle.
- R6: out_count increases by one, wrapping at its width, for each captured word. out_data is straight binary, with bit DW-1 as the most significant bit.
- R7: A request made while busy issues no start. If cfg_strict is 1, the request sets err_proto, which stays set until reset. If cfg_strict is 0, err_proto is not changed.
- R8: If the synchronized end-of-conversion level has not gone high by the time cfg_rise_max cycles have passed since the start, err_timeout is set (sticky) and the block returns to idle. No word is emitted.
- R9: If end-of-conversion stays high for more than cfg_fall_max cycles after its rise was seen, err_timeout is set (sticky) and the block returns to idle. No word is emitted.
- R10: With cfg_free_run set, starts are issued every cfg_period cycles. With cfg_drop_oldest clear, no start is issued while a word is waiting unaccepted.
- R11: With cfg_drop_oldest set, free-running starts continue while a word is waiting. Each new word replaces the waiting one and adds one to overrun_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_strict | input | 1 | Flag requests made while busy |
| cfg_free_run | input | 1 | Issue starts from the period timer |
| cfg_drop_oldest | input | 1 | Overwrite an unaccepted word instead of holding off |
| cfg_start_width | input | TW | Start pulse width in cycles |
| cfg_settle | input | TW | Extra cycles between the end-of-conversion fall and capture |
| cfg_rise_max | input | TW | Cycles from start allowed for end-of-conversion to rise |
| cfg_fall_max | input | TW | Cycles allowed for end-of-conversion to fall |
| cfg_period | input | PW | Free-running start period in cycles |
| req | input | 1 | Single-cycle conversion request |
| adc_start | output | 1 | Start line to the converter |
| adc_eoc | input | 1 | Asynchronous end-of-conversion from the converter |
| adc_data | input | DW | Parallel result word from the converter |
| out_valid | output | 1 | Captured word available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | DW | Captured word, straight binary |
| out_count | output | CW | Sample number of the word on out_data |
| busy | output | 1 | A request now would be refused |
| err_proto | output | 1 | Sticky: request made while busy in strict mode |
| err_timeout | output | 1 | Sticky: converter handshake timed out |
| overrun_count | output | CW | Words replaced before they were accepted |

## Verification
The bench builds the block with DW=12, TW=8, PW=10 and CW=3. The narrow sample counter wraps after eight words, so the table walk alone drives out_count through its wrap. The 10-bit period keeps free-running runs short enough to observe both hold-off and overrun within a few hundred cycles. A converter model in the bench answers each start with a chosen delay and conversion length, and can also stay silent or hold its end-of-conversion line high. This brings the capture latency, every start width including zero, and both timeout paths within reach.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_WRISE,
        ST_WFALL,
        ST_SETTLE
    } seq_state_e;

    localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/adc_eoc_sync.sv
module adc_eoc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eoc_async,
    output logic eoc_lvl,
    output logic eoc_rise,
    output logic eoc_fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q[0] <= eoc_async;
            prev_q     <= chain_q[STAGES-1];
        end
    end

    // Remaining synchronizer stages, one flop each.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[g] <= 1'b0;
            else        chain_q[g] <= chain_q[g-1];
        end
    end

    assign eoc_lvl  = chain_q[STAGES-1];
    assign eoc_rise = chain_q[STAGES-1] & ~prev_q;
    assign eoc_fall = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/adc_rate_timer.sv
module adc_rate_timer #(
    parameter int unsigned PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [PW-1:0] period,
    output logic          tick
);
    logic [PW-1:0] cnt_q, cnt_d;
    logic [PW:0]   cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        tick    = en && (cnt_inc >= {1'b0, period});
        if (!en)       cnt_d = '0;
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_inc[PW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int unsigned DW = 12,
    parameter int unsigned TW = 8,
    parameter int unsigned PW = 16,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_strict,
    input  logic          cfg_free_run,
    input  logic          cfg_drop_oldest,
    input  logic [TW-1:0] cfg_start_width,
    input  logic [TW-1:0] cfg_settle,
    input  logic [TW-1:0] cfg_rise_max,
    input  logic [TW-1:0] cfg_fall_max,
    input  logic [PW-1:0] cfg_period,
    input  logic          req,
    output logic          adc_start,
    input  logic          adc_eoc,
    input  logic [DW-1:0] adc_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic [CW-1:0] out_count,
    output logic          busy,
    output logic          err_proto,
    output logic          err_timeout,
    output logic [CW-1:0] overrun_count
);
    typedef struct packed {
        seq_state_e    st;
        logic [TW-1:0] tcnt;
        logic          seen;
        logic          start;
        logic          pend;
        logic          vld;
        logic [DW-1:0] data;
        logic [CW-1:0] cnt;
        logic [CW-1:0] ovr;
        logic          eproto;
        logic          etmo;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic          eoc_s, eoc_rise, eoc_fall;
    logic          tick;
    logic          busy_now;
    logic          launch;
    logic          seen_nx;
    logic [TW:0]   t_inc;

    adc_eoc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .eoc_async (adc_eoc),
        .eoc_lvl   (eoc_s),
        .eoc_rise  (eoc_rise),
        .eoc_fall  (eoc_fall)
    );

    adc_rate_timer #(.PW(PW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cfg_free_run),
        .period (cfg_period),
        .tick   (tick)
    );

    always_comb begin
        r_d      = r_q;
        t_inc    = {1'b0, r_q.tcnt} + 1'b1;
        seen_nx  = r_q.seen | eoc_rise | eoc_s;
        busy_now = (r_q.st != ST_IDLE) || eoc_s || (r_q.vld && !cfg_drop_oldest);
        launch   = !busy_now && (req || r_q.pend);

        // Consumer handshake.
        if (r_q.vld && out_ready) r_d.vld = 1'b0;

        // Remember one free-running tick until it can be served.
        if (!cfg_free_run) r_d.pend = 1'b0;
        else if (tick)     r_d.pend = 1'b1;

        // Refused request in strict mode.
        if (req && busy_now && cfg_strict) r_d.eproto = 1'b1;

        unique case (r_q.st)
            ST_IDLE: begin
                if (launch) begin
                    r_d.st    = ST_PULSE;
                    r_d.start = 1'b1;
                    r_d.tcnt  = '0;
                    r_d.seen  = 1'b0;
                    r_d.pend  = 1'b0;
                end
            end
            ST_PULSE: begin
                r_d.seen = seen_nx;
                if (t_inc >= {1'b0, cfg_start_width}) begin
                    r_d.start = 1'b0;
                    if (seen_nx) begin
                        r_d.st   = ST_WFALL;
                        r_d.tcnt = '0;
                    end else begin
                        r_d.st   = ST_WRISE;
                        r_d.tcnt = t_inc[TW-1:0];
                    end
                end else begin
                    r_d.tcnt = t_inc[TW-1:0];
                end
            end
            ST_WRISE: begin
                if (eoc_rise || eoc_s) begin
                    r_d.st   = ST_WFALL;
                    r_d.tcnt = '0;
                end else if (r_q.tcnt >= cfg_rise_max) begin
                    r_d.st   = ST_IDLE;
                    r_d.etmo = 1'b1;
                end else begin
                    r_d.tcnt = t_inc[TW-1:0];
                end
            end
            ST_WFALL: begin
                if (eoc_fall || !eoc_s) begin
                    r_d.st   = ST_SETTLE;
                    r_d.tcnt = '0;
                end else if (r_q.tcnt >= cfg_fall_max) begin
                    r_d.st   = ST_IDLE;
                    r_d.etmo = 1'b1;
                end else begin
                    r_d.tcnt = t_inc[TW-1:0];
                end
            end
            ST_SETTLE: begin
                if (r_q.tcnt >= cfg_settle) begin
                    if (r_q.vld && !out_ready) r_d.ovr = r_q.ovr + 1'b1;
                    r_d.vld  = 1'b1;
                    r_d.data = adc_data;
                    r_d.cnt  = r_q.cnt + 1'b1;
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.tcnt = t_inc[TW-1:0];
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign adc_start     = r_q.start;
    assign out_valid     = r_q.vld;
    assign out_data      = r_q.data;
    assign out_count     = r_q.cnt;
    assign busy          = busy_now;
    assign err_proto     = r_q.eproto;
    assign err_timeout   = r_q.etmo;
    assign overrun_count = r_q.ovr;
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
    parameter int unsigned DW = 12,
    parameter int unsigned CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          adc_start,
    input logic          eoc_s,
    input logic          busy,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data,
    input logic [CW-1:0] out_count,
    input logic          err_proto,
    input logic          err_timeout,
    input logic          cfg_drop_oldest
);
    assert_no_start_on_eoc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_start) |-> !$past(eoc_s));

    assert_start_is_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> busy);

    assert_hold_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !cfg_drop_oldest) |=> (out_valid && $stable(out_data)));

    assert_accept_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !cfg_drop_oldest) |=> !out_valid);

    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> ((out_count - $past(out_count)) == CW'(1)));

    assert_proto_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_proto |=> err_proto);

    assert_timeout_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |=> err_timeout);

    assert_holdoff_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(adc_start) && !cfg_drop_oldest) |-> !$past(out_valid));
endmodule

bind adc_conv_seq adc_conv_seq_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .adc_start       (adc_start),
    .eoc_s           (eoc_s),
    .busy            (busy),
    .out_valid       (out_valid),
    .out_ready       (out_ready),
    .out_data        (out_data),
    .out_count       (out_count),
    .err_proto       (err_proto),
    .err_timeout     (err_timeout),
    .cfg_drop_oldest (cfg_drop_oldest)
);

// File: tb/adc_conv_seq_bench.sv
module adc_conv_seq_bench;
    localparam int DW = 12;
    localparam int TW = 8;
    localparam int PW = 10;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_strict = 1'b0, cfg_free_run = 1'b0, cfg_drop_oldest = 1'b0;
    logic [TW-1:0] cfg_start_width = 8'd4, cfg_settle = 8'd2;
    logic [TW-1:0] cfg_rise_max = 8'd20, cfg_fall_max = 8'd100;
    logic [PW-1:0] cfg_period = 10'd40;
    logic          req = 1'b0;
    logic          adc_start;
    logic          adc_eoc = 1'b0;
    logic [DW-1:0] adc_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;
    logic [CW-1:0] out_count;
    logic          busy, err_proto, err_timeout;
    logic [CW-1:0] overrun_count;

    adc_conv_seq #(.DW(DW), .TW(TW), .PW(PW), .CW(CW)) u_adc_conv_seq (
        .clk(clk), .rst_n(rst_n), .cfg_strict(cfg_strict), .cfg_free_run(cfg_free_run),
        .cfg_drop_oldest(cfg_drop_oldest), .cfg_start_width(cfg_start_width),
        .cfg_settle(cfg_settle), .cfg_rise_max(cfg_rise_max), .cfg_fall_max(cfg_fall_max),
        .cfg_period(cfg_period), .req(req), .adc_start(adc_start), .adc_eoc(adc_eoc),
        .adc_data(adc_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_count(out_count), .busy(busy), .err_proto(err_proto),
        .err_timeout(err_timeout), .overrun_count(overrun_count)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    task automatic chk(input string rq, input bit ok, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Converter model: mode 0 answers, 1 stays silent, 2 holds EOC high.
    int            m_mode = 0;
    int            m_rise = 3;
    int            m_conv = 12;
    logic [DW-1:0] m_word = '0;
    logic [DW-1:0] last_word = '0;
    int            fall_cyc = 0;
    int            n_done = 0;

    initial begin
        forever begin
            @(posedge adc_start);
            @(negedge clk);
            if (m_mode != 1) begin
                repeat (m_rise) @(negedge clk);
                adc_eoc  = 1'b1;
                adc_data = 12'h0F0;
                repeat (m_conv) @(negedge clk);
                if (m_mode == 0) begin
                    fall_cyc  = cyc;
                    adc_eoc   = 1'b0;
                    adc_data  = m_word;
                    last_word = m_word;
                    m_word    = m_word + 12'h111;
                    n_done++;
                end
            end
        end
    end

    // Start pulse monitor.
    int n_pulses = 0;
    int run = 0;
    int last_pw = 0;
    int rise_cyc = 0;
    int last_gap = 0;
    bit prev_start = 1'b0;
    bit have_rise = 1'b0;

    initial begin
        forever begin
            @(negedge clk);
            if (adc_start && !prev_start) begin
                if (have_rise) last_gap = cyc - rise_cyc;
                rise_cyc  = cyc;
                have_rise = 1'b1;
            end
            if (adc_start) run++;
            else if (run != 0) begin
                last_pw = run;
                run = 0;
                n_pulses++;
            end
            prev_start = adc_start;
        end
    end

    typedef struct packed {
        logic [11:0] word;
        logic [7:0]  settle;
        logic [7:0]  width;
        logic [7:0]  rise;
        logic [7:0]  conv;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{12'hFFF, 8'd0, 8'd4,  8'd3,  8'd12},
        '{12'h000, 8'd3, 8'd1,  8'd2,  8'd15},
        '{12'h800, 8'd9, 8'd0,  8'd5,  8'd20},
        '{12'h001, 8'd1, 8'd13, 8'd1,  8'd14},
        '{12'h400, 8'd2, 8'd2,  8'd10, 8'd25},
        '{12'hC00, 8'd5, 8'd7,  8'd4,  8'd12},
        '{12'hA5A, 8'd0, 8'd3,  8'd6,  8'd18},
        '{12'h5A5, 8'd4, 8'd5,  8'd2,  8'd13},
        '{12'h7FF, 8'd1, 8'd6,  8'd3,  8'd16},
        '{12'h123, 8'd2, 8'd4,  8'd3,  8'd12}
    };

    int exp_cnt = 0;

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_cnt = 0;
        @(negedge clk);
    endtask

    task automatic pulse_req();
        @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_valid(output int lat);
        lat = -1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (out_valid) begin
                lat = cyc - fall_cyc;
                break;
            end
        end
    endtask

    task automatic accept();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        int lat;
        int np;
        int nd;
        int exp_pw;
        do_reset();

        // R1 reset state
        chk("R1", adc_start == 1'b0 && out_valid == 1'b0 && busy == 1'b0, adc_start, 0);
        chk("R1", out_count == 0 && overrun_count == 0, out_count, 0);
        chk("R1", err_proto == 1'b0 && err_timeout == 1'b0, err_proto, 0);

        // Table walk: R2, R4, R5, R6
        for (int v = 0; v < 10; v++) begin
            cfg_start_width = VECS[v].width;
            cfg_settle      = VECS[v].settle;
            m_rise          = int'(VECS[v].rise);
            m_conv          = int'(VECS[v].conv);
            m_word          = VECS[v].word;
            pulse_req();
            wait_valid(lat);
            exp_cnt = (exp_cnt + 1) % 8;
            exp_pw  = (VECS[v].width == 0) ? 1 : int'(VECS[v].width);
            chk("R4 data", out_data == VECS[v].word, out_data, VECS[v].word);
            chk("R4 latency", lat == int'(VECS[v].settle) + 4, lat, int'(VECS[v].settle) + 4);
            chk("R2 width", last_pw == exp_pw, last_pw, exp_pw);
            chk("R6 count", int'(out_count) == exp_cnt, out_count, exp_cnt);
            repeat (3) @(negedge clk);
            chk("R5 hold", out_valid && out_data == VECS[v].word, out_data, VECS[v].word);
            accept();
            chk("R5 accept", out_valid == 1'b0, out_valid, 0);
        end

        // R7 non-strict: refused request, no flag
        cfg_start_width = 8'd4; cfg_settle = 8'd2; m_rise = 3; m_conv = 15;
        np = n_pulses;
        pulse_req();
        repeat (8) @(negedge clk);
        pulse_req();
        wait_valid(lat);
        pulse_req();
        repeat (30) @(negedge clk);
        chk("R7 refused", n_pulses == np + 1, n_pulses, np + 1);
        chk("R7 nonstrict", err_proto == 1'b0, err_proto, 0);
        chk("R4 no pipeline", out_data == last_word, out_data, last_word);
        accept();

        // R7 strict: refused request sets sticky flag
        cfg_strict = 1'b1;
        np = n_pulses;
        pulse_req();
        repeat (8) @(negedge clk);
        pulse_req();
        wait_valid(lat);
        repeat (20) @(negedge clk);
        chk("R7 strict flag", err_proto == 1'b1, err_proto, 1);
        chk("R7 strict refused", n_pulses == np + 1, n_pulses, np + 1);
        accept();
        cfg_strict = 1'b0;
        pulse_req();
        wait_valid(lat);
        chk("R7 sticky", err_proto == 1'b1, err_proto, 1);
        accept();

        // R8 rise timeout
        do_reset();
        m_mode = 1;
        pulse_req();
        repeat (40) @(negedge clk);
        chk("R8 flag", err_timeout == 1'b1, err_timeout, 1);
        chk("R8 no data", out_valid == 1'b0 && out_count == 0, out_count, 0);
        chk("R8 idle", busy == 1'b0, busy, 0);
        m_mode = 0;

        // R9 fall timeout, then R3 start blocked while EOC high
        do_reset();
        m_mode = 2; cfg_fall_max = 8'd30; m_rise = 3; m_conv = 12;
        pulse_req();
        repeat (60) @(negedge clk);
        chk("R9 flag", err_timeout == 1'b1, err_timeout, 1);
        chk("R9 no data", out_valid == 1'b0 && out_count == 0, out_count, 0);
        chk("R3 busy on eoc", busy == 1'b1, busy, 1);
        np = n_pulses;
        pulse_req();
        repeat (12) @(negedge clk);
        chk("R3 no start", n_pulses == np && adc_start == 1'b0, n_pulses, np);
        adc_eoc = 1'b0;
        repeat (4) @(negedge clk);
        chk("R3 released", busy == 1'b0, busy, 0);
        m_mode = 0; cfg_fall_max = 8'd100;

        // R10 free-running hold-off and period
        do_reset();
        np = n_pulses;
        cfg_period = 10'd40; cfg_free_run = 1'b1; out_ready = 1'b0;
        repeat (200) @(negedge clk);
        chk("R10 holdoff", n_pulses == np + 1 && out_valid == 1'b1, n_pulses, np + 1);
        out_ready = 1'b1;
        repeat (240) @(negedge clk);
        chk("R10 period", last_gap == 40, last_gap, 40);
        cfg_free_run = 1'b0;
        repeat (60) @(negedge clk);
        out_ready = 1'b0;

        // R11 drop-oldest overrun counting
        do_reset();
        nd = n_done;
        cfg_drop_oldest = 1'b1; cfg_free_run = 1'b1;
        repeat (220) @(negedge clk);
        cfg_free_run = 1'b0;
        repeat (60) @(negedge clk);
        nd = n_done - nd;
        chk("R11 ran", nd >= 4, nd, 4);
        chk("R11 overrun", int'(overrun_count) == (nd - 1) % 8, overrun_count, (nd - 1) % 8);
        chk("R11 newest", out_valid && out_data == last_word, out_data, last_word);
        chk("R6 drop count", int'(out_count) == nd % 8, out_count, nd % 8);
        cfg_drop_oldest = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule